// File: doc/BRIEF.md
# Periodic Countdown Timer with Flag and Interrupt Styles

This block is a programmable periodic down-counter of the sort used beside a real-time clock. Software programs a reload value n, picks one of four tick rates and sets the run bit. On each tick of the chosen rate the live count drops by one. When a period of n ticks completes, the count reloads n on its own and a sticky timer flag is raised. The flag can feed an interrupt line, either as a single-cycle pulse per period or as a level that follows the flag. Only software can lower the flag.

The tick rates come from outside as single-cycle enable strobes in the system clock domain. Four strobes are provided, nominally 4.096 kHz, 64 Hz, 1 Hz and one per minute. There is no second clock domain. A small synchronous register port writes the reload value and the controls, clears the flag, and reads back the live count, the flag and the control setting. Writing n while the timer runs loads the count at once, and every later period also uses the new n.

Top module: `cdt_timer`

## Requirements
- R1: After reset the live count reads 0, the flag reads 0, the control register reads 0 and the interrupt output is low.
- R2: Control register (address 0) bits [2:1] pick the tick source: 0 = `tick_fast`, 1 = `tick_mid`, 2 = `tick_sec`, 3 = `tick_min`. Only a strobe on the selected source moves the count.
- R3: While the run bit (address 0, bit 0) is 0, the count holds, whatever the strobes do.
- R4: If the count is 1 when a selected tick arrives, that tick ends the period. The count reloads n and the flag (address 2, bit 0) becomes 1 in the same cycle, so one period lasts n ticks. Any other selected tick lowers the count by one.
- R5: The flag is cleared only by writing address 2 with bit 0 set. Writing address 2 with bit 0 clear leaves the flag as it was. If a period ends in the same cycle as a clear, the flag stays set.
- R6: With bit 4 of address 0 set (pulse style) and interrupts enabled, `irq` is high for exactly one clock cycle at each period end. That cycle is the one in which the flag first reads 1.
- R7: With bit 4 of address 0 clear (level style) and interrupts enabled, `irq` follows the flag. It stays high until software clears the flag.
- R8: With the interrupt enable (address 0, bit 3) clear, `irq` stays low, but the flag is still set at each period end.
- R9: A read of address 1 returns the live count, not the programmed n.
- R10: A write of n to address 1 loads the count in the next cycle, even in mid-period. Every later period reloads the new n.
- R11: With n = 0 the count never moves and the flag is never set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_fast | input | 1 | Tick strobe, source 0 (4.096 kHz nominal) |
| tick_mid | input | 1 | Tick strobe, source 1 (64 Hz nominal) |
| tick_sec | input | 1 | Tick strobe, source 2 (1 Hz nominal) |
| tick_min | input | 1 | Tick strobe, source 3 (1/60 Hz nominal) |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 control, 1 reload/count, 2 flag |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data for `reg_addr` (combinational) |
| irq | output | 1 | Interrupt output, active high |

## Verification
A count that has gone wrong shows up on the next read of address 1. A count stuck at a wrong value also moves the flag's rise by at least one selected tick, so a wrong reload or a source decoded wrongly is seen within one period. A flag that is lost or raised when it should not be shows in the same cycle in level style, through `irq`, and otherwise at the next flag read. A pulse that lasts too long shows as `irq` still high one clock after the period end.

// File: rtl/cdt_pkg.sv
`timescale 1ns/1ps
package cdt_pkg;

  typedef enum logic [1:0] {
    SRC_FAST = 2'd0,
    SRC_MID  = 2'd1,
    SRC_SEC  = 2'd2,
    SRC_MIN  = 2'd3
  } src_e;

  // control register layout, MSB first: pulse(4) ie(3) src(2:1) run(0)
  typedef struct packed {
    logic pulse;
    logic ie;
    src_e src;
    logic run;
  } ctrl_t;

  localparam int unsigned CTRL_W  = $bits(ctrl_t);
  localparam int unsigned N_SRC   = 4;
  localparam logic [1:0]  A_CTRL  = 2'd0;
  localparam logic [1:0]  A_COUNT = 2'd1;
  localparam logic [1:0]  A_FLAG  = 2'd2;

  // a selected tick finishes the period when the count is at or below one
  function automatic logic cdt_last(input logic [31:0] cnt);
    return cnt <= 32'd1;
  endfunction

endpackage

// File: rtl/cdt_tick_sel.sv
`timescale 1ns/1ps
module cdt_tick_sel #(
  parameter int unsigned N_SRC = 4,
  localparam int unsigned SEL_W = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0] ticks,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  logic [N_SRC-1:0] hit;

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    assign hit[g] = ticks[g] & (sel == SEL_W'(g));
  end

  assign tick = |hit;
endmodule

// File: rtl/cdt_counter.sv
`timescale 1ns/1ps
module cdt_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] n_val,
  output logic [CNT_W-1:0] count,
  output logic             period_end
);
  import cdt_pkg::*;

  logic step;
  logic at_last;

  assign step       = run & tick & (n_val != '0) & ~load;
  assign at_last    = cdt_last(32'(count));
  assign period_end = step & at_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
    end else if (load) begin
      count <= load_val;
    end else if (step) begin
      count <= at_last ? n_val : count - 1'b1;
    end
  end
endmodule

// File: rtl/cdt_irq_ctl.sv
`timescale 1ns/1ps
module cdt_irq_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic period_end,
  input  logic clr_req,
  input  logic ie,
  input  logic pulse_mode,
  output logic flag,
  output logic pulse_q,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag    <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= period_end;
      if (period_end) begin
        flag <= 1'b1;
      end else if (clr_req) begin
        flag <= 1'b0;
      end
    end
  end

  always_comb begin
    if (!ie) begin
      irq = 1'b0;
    end else if (pulse_mode) begin
      irq = pulse_q;
    end else begin
      irq = flag;
    end
  end
endmodule

// File: rtl/cdt_timer.sv
`timescale 1ns/1ps
module cdt_timer #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_fast,
  input  logic              tick_mid,
  input  logic              tick_sec,
  input  logic              tick_min,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  import cdt_pkg::*;

  localparam int unsigned SEL_W = $clog2(N_SRC);

  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] n_q;
  logic [CNT_W-1:0] count;
  logic             tick_sel;
  logic             period_end;
  logic             n_load;
  logic             ctrl_wr;
  logic             flag_clr;
  logic             flag;
  logic             pulse_q;
  logic [N_SRC-1:0] tick_vec;

  assign tick_vec = {tick_min, tick_sec, tick_mid, tick_fast};
  assign n_load   = reg_we & (reg_addr == A_COUNT);
  assign ctrl_wr  = reg_we & (reg_addr == A_CTRL);
  assign flag_clr = reg_we & (reg_addr == A_FLAG) & reg_wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      n_q    <= '0;
    end else begin
      if (ctrl_wr) ctrl_q <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
      if (n_load)  n_q    <= reg_wdata[CNT_W-1:0];
    end
  end

  cdt_tick_sel #(.N_SRC(N_SRC)) u_sel (
    .ticks (tick_vec),
    .sel   (SEL_W'(ctrl_q.src)),
    .tick  (tick_sel)
  );

  cdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (ctrl_q.run),
    .tick       (tick_sel),
    .load       (n_load),
    .load_val   (reg_wdata[CNT_W-1:0]),
    .n_val      (n_q),
    .count      (count),
    .period_end (period_end)
  );

  cdt_irq_ctl u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .period_end (period_end),
    .clr_req    (flag_clr),
    .ie         (ctrl_q.ie),
    .pulse_mode (ctrl_q.pulse),
    .flag       (flag),
    .pulse_q    (pulse_q),
    .irq        (irq)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL:  reg_rdata[CTRL_W-1:0] = ctrl_q;
      A_COUNT: reg_rdata[CNT_W-1:0]  = count;
      A_FLAG:  reg_rdata[0]          = flag;
      default: reg_rdata             = '0;
    endcase
  end
endmodule

// File: rtl/cdt_timer_chk.sv
`timescale 1ns/1ps
module cdt_timer_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             ie,
  input logic             pulse_mode,
  input logic [CNT_W-1:0] n_val,
  input logic [CNT_W-1:0] count,
  input logic             period_end,
  input logic             flag,
  input logic             clr_req,
  input logic             n_load,
  input logic             reg_we,
  input logic             irq
);
  // R3: stopped timer keeps its count unless n is written
  assert_hold_stopped_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !n_load) |=> $stable(count));

  // R4: a period end reloads n and raises the flag
  assert_reload_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (period_end && !n_load) |=> (flag && count == $past(n_val)));

  // R5: only a clear request lowers the flag
  assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr_req) |=> flag);

  // R6: a pulse does not stretch into the next cycle
  assert_pulse_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_mode && irq && !period_end && !reg_we) |=> !irq);

  // R8: disabled interrupt never drives the line
  assert_irq_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ie |-> !irq);

  // R11: a zero reload never ends a period
  assert_zero_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (n_val == '0) |-> !period_end);
endmodule

bind cdt_timer cdt_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .run        (ctrl_q.run),
  .ie         (ctrl_q.ie),
  .pulse_mode (ctrl_q.pulse),
  .n_val      (n_q),
  .count      (count),
  .period_end (period_end),
  .flag       (flag),
  .clr_req    (flag_clr),
  .n_load     (n_load),
  .reg_we     (reg_we),
  .irq        (irq)
);

// File: tb/tb_cdt_timer.sv
`timescale 1ns/1ps
module tb_cdt_timer;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick_fast = 0, tick_mid = 0, tick_sec = 0, tick_min = 0;
  logic          reg_we = 0;
  logic [1:0]    reg_addr = 0;
  logic [DW-1:0] reg_wdata = 0;
  logic [DW-1:0] reg_rdata;
  logic          irq;

  always #2.5 clk = ~clk;

  cdt_timer #(.DATA_W(DW), .CNT_W(DW)) dut (
    .clk(clk), .rst_n(rst_n),
    .tick_fast(tick_fast), .tick_mid(tick_mid), .tick_sec(tick_sec), .tick_min(tick_min),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  typedef struct {
    int    kind;   // 0: reg_rdata, 1: irq
    int    exp;
    string tag;
  } item_t;

  item_t q[$];
  int total = 0;
  int bad = 0;
  bit done = 0;

  // bench model of the timer, built from the requirements
  int m_n = 0, m_cnt = 0, m_flag = 0, m_ctrl = 0;

  // monitor: compares every queued expectation at the falling edge
  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      int act;
      it = q.pop_front();
      act = (it.kind == 1) ? int'(irq) : int'(reg_rdata);
      total++;
      if (act != it.exp) begin
        bad++;
        $display("FAIL %s actual=%0d expected=%0d", it.tag, act, it.exp);
      end
    end
  end

  task automatic expect_item(input int kind, input logic [1:0] a, input int exp, input string tag);
    item_t it;
    reg_addr = a;
    it.kind = kind; it.exp = exp; it.tag = tag;
    q.push_back(it);
    @(negedge clk); #1;
  endtask

  task automatic chk_cnt(input string tag);  expect_item(0, 2'd1, m_cnt, tag);  endtask
  task automatic chk_flag(input string tag); expect_item(0, 2'd2, m_flag, tag); endtask
  task automatic chk_irq(input int e, input string tag); expect_item(1, 2'd0, e, tag); endtask

  task automatic wr(input logic [1:0] a, input int d);
    @(posedge clk); #1;
    reg_we = 1; reg_addr = a; reg_wdata = DW'(d);
    @(posedge clk); #1;
    reg_we = 0;
    if (a == 2'd0) m_ctrl = d;
    if (a == 2'd1) begin m_n = d; m_cnt = d; end
    if (a == 2'd2 && d[0]) m_flag = 0;
  endtask

  function automatic void model_tick(input int which);
    if ((m_ctrl & 1) != 0 && ((m_ctrl >> 1) & 3) == which && m_n != 0) begin
      if (m_cnt <= 1) begin m_cnt = m_n; m_flag = 1; end
      else m_cnt = m_cnt - 1;
    end
  endfunction

  task automatic tick(input int which);
    @(posedge clk); #1;
    tick_fast = (which == 0); tick_mid = (which == 1);
    tick_sec  = (which == 2); tick_min = (which == 3);
    @(posedge clk); #1;
    tick_fast = 0; tick_mid = 0; tick_sec = 0; tick_min = 0;
    model_tick(which);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog all-reqs actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk); #1;

    // R1 reset state
    chk_cnt("R1 count after reset");
    chk_flag("R1 flag after reset");
    expect_item(0, 2'd0, 0, "R1 control after reset");
    chk_irq(0, "R1 irq after reset");

    // R10 load n, then run fast source, pulse style, irq enabled
    wr(2'd1, 3);
    chk_cnt("R10 write n loads count");
    wr(2'd0, 'h19);
    expect_item(0, 2'd0, 'h19, "R2 control readback");
    tick(1);
    chk_cnt("R2 unselected source ignored");
    tick(0);
    chk_cnt("R9 live count after one tick");
    tick(0);
    chk_cnt("R4 count two below");
    tick(0);
    chk_irq(1, "R6 pulse at period end");
    chk_irq(0, "R6 pulse lasts one cycle");
    chk_cnt("R4 reload after n ticks");
    chk_flag("R4 flag set at period end");

    // R5 clear semantics
    wr(2'd2, 0);
    chk_flag("R5 write without bit0 keeps flag");
    wr(2'd2, 1);
    chk_flag("R5 write bit0 clears flag");

    // R7 level style
    wr(2'd0, 'h09);
    tick(0); tick(0); tick(0);
    chk_irq(1, "R7 level irq on flag");
    chk_irq(1, "R7 level irq holds");
    wr(2'd2, 1);
    chk_irq(0, "R7 level irq drops with clear");

    // R8 irq disabled
    wr(2'd0, 'h01);
    tick(0); tick(0); tick(0);
    chk_flag("R8 flag still set with ie low");
    chk_irq(0, "R8 irq low with ie low");
    wr(2'd2, 1);

    // R3 stopped
    wr(2'd0, 'h00);
    tick(0); tick(0);
    chk_cnt("R3 count held while stopped");

    // R2 seconds and minutes sources
    wr(2'd0, 'h05);
    tick(0);
    chk_cnt("R2 fast ignored on seconds source");
    tick(2);
    chk_cnt("R2 seconds source decrements");
    wr(2'd0, 'h07);
    tick(2);
    chk_cnt("R2 seconds ignored on minutes source");
    tick(3);
    chk_cnt("R2 minutes source decrements");

    // R10 mid-period rewrite of n
    wr(2'd1, 5);
    chk_cnt("R10 mid-period write loads count");
    for (int i = 0; i < 4; i++) tick(3);
    chk_cnt("R10 count after four ticks");
    chk_flag("R10 flag not yet set");
    tick(3);
    chk_flag("R10 flag after new n ticks");
    chk_cnt("R10 reload uses new n");
    wr(2'd2, 1);

    // R11 zero reload
    wr(2'd1, 0);
    for (int i = 0; i < 3; i++) tick(3);
    chk_cnt("R11 zero n does not count");
    chk_flag("R11 zero n never sets flag");

    // R5 set wins over same-cycle clear
    wr(2'd1, 1);
    @(posedge clk); #1;
    reg_we = 1; reg_addr = 2'd2; reg_wdata = 1; tick_min = 1;
    @(posedge clk); #1;
    reg_we = 0; tick_min = 0;
    m_flag = 1; m_cnt = 1;
    chk_flag("R5 period end beats clear");
    chk_cnt("R4 n=1 reload every tick");

    repeat (2) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule